// File: doc/BRIEF.md
# Open-Drain Bus Arbitration Monitor

This block sits between the bit-level control of a multi-master two-wire serial master and its SDA and SCL pads. Each pad is run as an emulated open-drain pin. The data value presented to the pad is tied low, and only the output enable is switched. A requested '0' turns the low driver on. A requested '1' turns it off, and the external pull-up then raises the line.

The block watches the bus to detect a lost arbitration. Both bus levels pass through a synchronizer. When the caller pulses a sample strobe while the synchronized SCL is high, the block compares the SDA level it meant to leave high against the synchronized SDA level. If it released SDA and still finds the line low, another master has won. The block then releases both lines at once and keeps them released. It records whether the loss came during the address phase or the data phase. A loss in the data phase raises a retry flag. The status stays set until a clear pulse or a reset.

Top module: `odbus_arb_monitor`

## Requirements
- R1: The pad data outputs `sda_drv_o` and `scl_drv_o` are 0 at all times, including during reset.
- R2: While no loss is recorded, `sda_oe` equals the inverse of `sda_want` and `scl_oe` equals the inverse of `scl_want`, one clock after those inputs are applied. `oe`=1 means the low driver is on.
- R3: A cycle in which `sda_want` is 0 never records a loss, whatever the bus levels are.
- R4: A loss is recorded when `strobe`=1, the synchronized SCL is 1, `sda_want`=1 and the synchronized SDA is 0. `arb_lost` goes to 1 on the clock edge that samples that strobe. Without `strobe`, or with the synchronized SCL at 0, no loss is recorded.
- R5: In every cycle where `arb_lost` is 1, both `sda_oe` and `scl_oe` are 0, including the first such cycle.
- R6: At the loss, `lost_in_address` is set if `phase_data`=0, and `retry_needed` is set if `phase_data`=1. Exactly one of the two is 1 while `arb_lost` is 1, and both are 0 otherwise.
- R7: `arb_lost` and its phase flag hold until `clear` is pulsed. Further strobes, mismatches or phase changes do not alter them. After the clear, the enables follow the wants again.
- R8: During and right after reset, all enables and all status outputs are 0.
- R9: `sda_bus` and `scl_bus` pass through SYNC_STAGES flops (default 2, reset to 1) before they are compared. A level that changes fewer than SYNC_STAGES edges before the strobe is sampled is not yet seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_want | input | 1 | Intended SDA bit (1 = release) |
| scl_want | input | 1 | Intended SCL bit (1 = release) |
| phase_data | input | 1 | 0 = address transfer, 1 = data transfer |
| strobe | input | 1 | One-cycle compare request |
| clear | input | 1 | Clears recorded loss |
| sda_bus | input | 1 | Raw SDA level from pad |
| scl_bus | input | 1 | Raw SCL level from pad |
| sda_drv_o | output | 1 | SDA pad data, fixed low |
| scl_drv_o | output | 1 | SCL pad data, fixed low |
| sda_oe | output | 1 | SDA low-driver enable |
| scl_oe | output | 1 | SCL low-driver enable |
| arb_lost | output | 1 | Arbitration lost, sticky |
| lost_in_address | output | 1 | Loss happened in address phase |
| retry_needed | output | 1 | Loss happened in data phase; resend later |

## Verification
The hardest situation to reach is a strobe that lands inside the synchronizer latency. In that case the raw SDA is already low, but the synchronized copy still shows the old high level, so no loss may be recorded. The bench reaches it by moving the raw bus level and the strobe on the same falling edge. The bench also sweeps every combination of intended bit, bus levels, strobe and phase after a full settling delay. It then drives mismatches after a loss to show that the status holds until a clear.

// File: rtl/odbus_pkg.sv
package odbus_pkg;
    typedef struct packed {
        logic sda_oe;
        logic scl_oe;
        logic lost;
        logic in_addr;
        logic retry;
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{default: 1'b0};
endpackage

// File: rtl/odbus_sync.sv
module odbus_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '1;
                end else if (s == 0) begin
                    chain_q[s] <= d_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/odbus_arb_detect.sv
module odbus_arb_detect (
    input  logic strobe,
    input  logic scl_level,
    input  logic sda_level,
    input  logic sda_want,
    input  logic already_lost,
    output logic mismatch
);
    logic compare_window;
    logic released_high;

    always_comb begin
        compare_window = strobe & scl_level;
        released_high  = sda_want;
        mismatch       = compare_window & released_high & ~sda_level & ~already_lost;
    end
endmodule

// File: rtl/odbus_arb_monitor.sv
module odbus_arb_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_want,
    input  logic scl_want,
    input  logic phase_data,
    input  logic strobe,
    input  logic clear,
    input  logic sda_bus,
    input  logic scl_bus,
    output logic sda_drv_o,
    output logic scl_drv_o,
    output logic sda_oe,
    output logic scl_oe,
    output logic arb_lost,
    output logic lost_in_address,
    output logic retry_needed
);
    import odbus_pkg::*;

    localparam int LINES = 2;

    logic [LINES-1:0] bus_sync;
    logic             sda_s;
    logic             scl_s;
    logic             hit;
    arb_state_t       st_d;
    arb_state_t       st_q;

    odbus_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_bus, sda_bus}),
        .q_o   (bus_sync)
    );

    assign sda_s = bus_sync[0];
    assign scl_s = bus_sync[1];

    odbus_arb_detect u_detect (
        .strobe       (strobe),
        .scl_level    (scl_s),
        .sda_level    (sda_s),
        .sda_want     (sda_want),
        .already_lost (st_q.lost),
        .mismatch     (hit)
    );

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.lost    = 1'b1;
            st_d.in_addr = ~phase_data;
            st_d.retry   = phase_data;
        end else if (clear) begin
            st_d.lost    = 1'b0;
            st_d.in_addr = 1'b0;
            st_d.retry   = 1'b0;
        end
        st_d.sda_oe = ~st_d.lost & ~sda_want;
        st_d.scl_oe = ~st_d.lost & ~scl_want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARB_RESET;
        else        st_q <= st_d;
    end

    assign sda_drv_o       = 1'b0;
    assign scl_drv_o       = 1'b0;
    assign sda_oe          = st_q.sda_oe;
    assign scl_oe          = st_q.scl_oe;
    assign arb_lost        = st_q.lost;
    assign lost_in_address = st_q.in_addr;
    assign retry_needed    = st_q.retry;
endmodule

// File: rtl/odbus_arb_checker.sv
module odbus_arb_checker (
    input logic clk,
    input logic rst_n,
    input logic sda_want,
    input logic strobe,
    input logic clear,
    input logic sda_oe,
    input logic scl_oe,
    input logic arb_lost,
    input logic lost_in_address,
    input logic retry_needed
);
    AST_LOST_RELEASES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (!sda_oe && !scl_oe)); // R5

    AST_LOW_NEVER_CHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_want |=> !$rose(arb_lost)); // R3

    AST_NO_STROBE_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !$rose(arb_lost)); // R4

    AST_ONE_PHASE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> $countones({lost_in_address, retry_needed}) == 1); // R6

    AST_NO_FLAG_WITHOUT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_lost |-> (!lost_in_address && !retry_needed)); // R6

    AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !clear) |=> (arb_lost && $stable(lost_in_address))); // R7
endmodule

bind odbus_arb_monitor odbus_arb_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sda_want        (sda_want),
    .strobe          (strobe),
    .clear           (clear),
    .sda_oe          (sda_oe),
    .scl_oe          (scl_oe),
    .arb_lost        (arb_lost),
    .lost_in_address (lost_in_address),
    .retry_needed    (retry_needed)
);

// File: tb/sim_odbus_arb_monitor.sv
module sim_odbus_arb_monitor;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda_want = 1'b1, scl_want = 1'b1, phase_data = 1'b0;
    logic strobe = 1'b0, clear = 1'b0, sda_bus = 1'b1, scl_bus = 1'b1;
    logic sda_drv_o, scl_drv_o, sda_oe, scl_oe, arb_lost, lost_in_address, retry_needed;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    odbus_arb_monitor u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input int act, input int exp, input string req);
        check(act == exp, req, act, exp);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk_eq(sda_oe, 0, "R8 sda_oe"); chk_eq(scl_oe, 0, "R8 scl_oe");
        chk_eq(arb_lost, 0, "R8 lost"); chk_eq(lost_in_address, 0, "R8 addr");
        chk_eq(retry_needed, 0, "R8 retry");
        chk_eq(sda_drv_o, 0, "R1 sda during reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq(arb_lost, 0, "R8 after reset");

        // Exhaustive sweep: sda_want, scl_want, sda_bus, scl_bus, strobe, phase
        for (int v = 0; v < 64; v++) begin
            bit w, cw, sb, cb, st, ph, exp_lost;
            w = v[0]; cw = v[1]; sb = v[2]; cb = v[3]; st = v[4]; ph = v[5];
            sda_want = w; scl_want = cw; sda_bus = sb; scl_bus = cb; phase_data = ph;
            repeat (3) @(negedge clk);
            chk_eq(sda_oe, !w, "R2 sda_oe follows");
            chk_eq(scl_oe, !cw, "R2 scl_oe follows");
            strobe = st;
            @(negedge clk);
            strobe = 1'b0;
            exp_lost = st & cb & w & !sb;
            chk_eq(arb_lost, exp_lost, exp_lost ? "R4 loss" : (w ? "R4 no loss" : "R3 low unchecked"));
            chk_eq(lost_in_address, exp_lost & !ph, "R6 addr flag");
            chk_eq(retry_needed, exp_lost & ph, "R6 retry flag");
            chk_eq(sda_oe, exp_lost ? 0 : !w, "R5 sda released");
            chk_eq(scl_oe, exp_lost ? 0 : !cw, "R5 scl released");
            chk_eq(sda_drv_o | scl_drv_o, 0, "R1 pads low");
            do_clear();
            chk_eq(arb_lost, 0, "R7 cleared");
            sda_bus = 1'b1; scl_bus = 1'b1;
            repeat (3) @(negedge clk);
        end

        // R7 sticky: lose in address, then try data-phase mismatches
        sda_want = 1'b1; scl_want = 1'b0; phase_data = 1'b0; sda_bus = 1'b0;
        repeat (3) @(negedge clk);
        strobe = 1'b1; @(negedge clk); strobe = 1'b0;
        chk_eq(arb_lost, 1, "R7 set");
        phase_data = 1'b1; sda_want = 1'b0;
        for (int k = 0; k < 4; k++) begin
            strobe = k[0]; sda_want = k[1];
            @(negedge clk);
            chk_eq(arb_lost, 1, "R7 held");
            chk_eq(lost_in_address, 1, "R7 phase held");
            chk_eq(retry_needed, 0, "R7 retry unchanged");
            chk_eq(sda_oe | scl_oe, 0, "R7 lines stay released");
        end
        strobe = 1'b0; sda_want = 1'b0;
        do_clear();
        chk_eq(sda_oe, 1, "R7 sda resumes after clear");
        chk_eq(scl_oe, 1, "R7 scl resumes after clear");

        // R9 synchronizer latency: strobe in same cycle bus falls
        sda_want = 1'b1; sda_bus = 1'b1; scl_bus = 1'b1;
        repeat (3) @(negedge clk);
        sda_bus = 1'b0; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk_eq(arb_lost, 0, "R9 one stage not seen");
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk_eq(arb_lost, 0, "R9 second edge not seen");
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk_eq(arb_lost, 1, "R9 seen after stages");
        do_clear();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule